// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves a programmed number of data items from a source region to a destination region. Each item takes two bus accesses on a simple master interface: a read from the current source address, then a write of the returned data to the current destination address. Software-facing logic outside the block holds the programmed source base, destination base, item count, the per-side address modes and the item width. The engine shows its progress through current-address and remaining-count outputs. It reports completion and bus errors as one-cycle event pulses for an interrupt unit.

Each side's address can step forward by the item size, stay fixed, or wrap. When the count runs out in wrap mode, every wrapping side reloads its base address, the count reloads, and the transfer starts again without a new start pulse. This repeats until the channel enable is taken away. A bus error response stops the engine and locks it. Only an engine reset clears the lock.

Top module: `dma_xfer_engine`

## Requirements
- R1: After `rst_n` is released, `m_req`, `xfer_active`, `soft_rst_busy`, `cur_count`, `cur_src` and `cur_dst` are all zero.
- R2: A one-cycle `start` loads `cur_src`, `cur_dst` and `cur_count` from `src_base`, `dst_base` and `xfer_count` and raises `xfer_active`. This happens only when all of the following hold: the engine is idle, `chan_en` is 1, `xfer_count` is nonzero, the engine is not locked, and no engine reset is running. In every other case `start` is ignored.
- R3: Each item is a read (`m_we`=0) at `cur_src`, followed by a write (`m_we`=1) at `cur_dst`. While `m_ack` is low, a pending request holds `m_req`, `m_addr` and `m_we` unchanged.
- R4: `width` selects the item size: 00 is 32-bit, 01 is 8-bit, 10 is 16-bit, and 11 is treated as 32-bit. `m_size` gives 0 for a byte, 1 for a half-word and 2 for a word. The written data is the read data with the bits above the item width forced to zero.
- R5: The address modes `src_mode` and `dst_mode` behave as follows after each error-free write:
  - 00 (and the reserved 01): the address moves up by 1, 2 or 4 bytes, matching the item size.
  - 10: the address stays fixed.
  - 11: the address moves up as in 00, and wraps as described in R8.
- R6: `cur_count` drops by one after each error-free write, and the current-address outputs show each step as it happens.
- R7: When neither mode is 11 and the count reaches zero, `evt_done` pulses for exactly one cycle, `xfer_active` falls, and no further request is made.
- R8: When either mode is 11 and the count reaches zero:
  - each side in mode 11 reloads its base address, and `cur_count` reloads from `xfer_count`;
  - a side in another mode keeps stepping from where it is;
  - `evt_done` pulses once;
  - the next item starts without a new `start`.
- R9: When `chan_en` is low, the bus access in flight completes, the engine then goes idle and `xfer_active` falls. A read that completes with the enable low is never written.
- R10: When `m_err` arrives with `m_ack`, `evt_abort` pulses for one cycle and the engine goes idle with `xfer_active` low and `cur_count` unchanged. After that, every `start` is ignored until an engine reset.
- R11: A one-cycle `sw_reset` drives `soft_rst_busy` high for exactly RST_CYCLES cycles, during which `m_req` stays low. It clears the current registers and the error lock. The programmed inputs are unaffected, so the next `start` runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| start | input | 1 | One-cycle transfer start |
| sw_reset | input | 1 | One-cycle engine reset request |
| src_mode | input | 2 | Source address mode |
| dst_mode | input | 2 | Destination address mode |
| width | input | 2 | Item width code |
| src_base | input | AW | Programmed source address |
| dst_base | input | AW | Programmed destination address |
| xfer_count | input | CW | Programmed item count |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |
| cur_count | output | CW | Items remaining |
| xfer_active | output | 1 | Transfer armed; falls on completion, abort or disable |
| soft_rst_busy | output | 1 | Engine reset in progress |
| m_req | output | 1 | Bus request |
| m_we | output | 1 | Bus write (1) or read (0) |
| m_addr | output | AW | Bus address |
| m_size | output | 2 | Access size code |
| m_wdata | output | DW | Bus write data |
| m_ack | input | 1 | Bus response; completes the access |
| m_err | input | 1 | Error response, valid with m_ack |
| m_rdata | input | DW | Read data, valid with m_ack |
| evt_done | output | 1 | Completion or wrap-reload pulse |
| evt_abort | output | 1 | Bus error pulse |

## Verification
The assertions take for granted that the bus side is well behaved:
- `m_ack` and `m_err` are driven only while `m_req` is high;
- `m_ack` lasts one cycle per access;
- `m_err` is meaningful only together with `m_ack`.

They also assume that `start` and `sw_reset` are single-cycle pulses and that `xfer_count` stays steady while an item is in flight. The bench bus model answers only a raised request and alternates between an acknowledge cycle and a quiet cycle, so every access is acknowledged exactly once. It returns an error only for addresses in the top 256 MiB. Configuration is changed only while the engine is idle, apart from the enable drop that is timed to a chosen access.

// File: rtl/dma_eng_pkg.sv
// Package: shared codes and small helpers for the DMA transfer engine.
// Assumes callers pass the raw 2-bit mode and width codes from configuration.
package dma_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    localparam logic [1:0] AM_INC   = 2'b00;
    localparam logic [1:0] AM_RSV   = 2'b01;
    localparam logic [1:0] AM_FIXED = 2'b10;
    localparam logic [1:0] AM_WRAP  = 2'b11;

    localparam logic [1:0] BW_WORD = 2'b00;
    localparam logic [1:0] BW_BYTE = 2'b01;
    localparam logic [1:0] BW_HALF = 2'b10;

    // Bus size code for a width code; the reserved code behaves as a word.
    function automatic logic [1:0] width_size(input logic [1:0] w);
        case (w)
            BW_BYTE: return 2'd0;
            BW_HALF: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // Address step in bytes for a width code.
    function automatic logic [2:0] width_step(input logic [1:0] w);
        case (w)
            BW_BYTE: return 3'd1;
            BW_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_track.sv
// Module: dma_addr_track
// Holds one side's current address. Priority: clear, load, reload, advance.
// Assumes the advance request comes only after an error-free write.
module dma_addr_track
    import dma_eng_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic          reload,
    input  logic          advance,
    input  logic [1:0]    mode,
    input  logic [2:0]    step,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] cur
);

    logic moves;
    assign moves = (mode != AM_FIXED);

    // Current address register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cur <= '0;
        else if (clear)             cur <= '0;
        else if (load || reload)    cur <= base;
        else if (advance && moves)  cur <= cur + AW'(step);
    end

endmodule

// File: rtl/dma_beat_count.sv
// Module: dma_beat_count
// Remaining item counter. Priority: clear, load/reload, decrement.
// Assumes decrement is never requested at zero (the sequencer reloads or stops).
module dma_beat_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic          dec,
    input  logic [CW-1:0] value,
    output logic [CW-1:0] cur
);

    // Remaining count register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur <= '0;
        else if (clear)  cur <= '0;
        else if (load)   cur <= value;
        else if (dec)    cur <= cur - CW'(1);
    end

endmodule

// File: rtl/dma_seq_fsm.sv
// Module: dma_seq_fsm
// Sequencer: read-then-write items, completion, wrap restart, disable,
// error lock and the timed engine reset. Drives the bus master signals.
// Assumes m_ack/m_err come only while m_req is high, one cycle per access.
module dma_seq_fsm
    import dma_eng_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int CW         = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          start,
    input  logic          sw_reset,
    input  logic [1:0]    src_mode,
    input  logic [1:0]    dst_mode,
    input  logic [1:0]    width,
    input  logic [CW-1:0] cfg_count,
    input  logic [AW-1:0] cur_src,
    input  logic [AW-1:0] cur_dst,
    input  logic [CW-1:0] cur_count,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_size,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    input  logic          m_err,
    input  logic [DW-1:0] m_rdata,
    output logic          ctl_clear,
    output logic          ctl_load,
    output logic          ctl_advance,
    output logic          ctl_reload_src,
    output logic          ctl_reload_dst,
    output logic          ctl_reload_cnt,
    output logic          ctl_dec,
    output logic          xfer_active,
    output logic          soft_rst_busy,
    output logic          evt_done,
    output logic          evt_abort
);

    localparam int RCW = $clog2(RST_CYCLES + 1);

    seq_state_e    state;
    logic          armed;
    logic          locked;
    logic [RCW-1:0] rst_cnt;
    logic [DW-1:0] data_buf;

    logic          wrap_any;
    logic          last_item;
    logic          start_ok;
    logic          wr_ok;
    logic          wrap_point;
    logic [DW-1:0] data_mask;

    // Decode of the current condition.
    always_comb begin
        wrap_any   = (src_mode == AM_WRAP) || (dst_mode == AM_WRAP);
        last_item  = (cur_count == CW'(1));
        start_ok   = start && enable && !armed && !locked && !soft_rst_busy
                     && (cfg_count != '0) && (state == ST_IDLE) && !sw_reset;
        wr_ok      = (state == ST_WRITE) && m_ack && !m_err && !sw_reset;
        wrap_point = wr_ok && last_item && wrap_any;
        case (width)
            BW_BYTE: data_mask = DW'(8'hFF);
            BW_HALF: data_mask = DW'(16'hFFFF);
            default: data_mask = '1;
        endcase
    end

    // Control strobes to the address trackers and the counter.
    always_comb begin
        ctl_clear      = sw_reset;
        ctl_load       = start_ok;
        ctl_advance    = wr_ok;
        ctl_reload_src = wrap_point && (src_mode == AM_WRAP);
        ctl_reload_dst = wrap_point && (dst_mode == AM_WRAP);
        ctl_reload_cnt = wrap_point;
        ctl_dec        = wr_ok && !wrap_point;
    end

    // Bus master outputs follow the state.
    always_comb begin
        m_req         = (state != ST_IDLE);
        m_we          = (state == ST_WRITE);
        m_addr        = (state == ST_WRITE) ? cur_dst : cur_src;
        m_size        = width_size(width);
        m_wdata       = data_buf;
        xfer_active   = armed;
        soft_rst_busy = (rst_cnt != '0);
    end

    // Sequencer state, lock, reset timer, data buffer and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            armed     <= 1'b0;
            locked    <= 1'b0;
            rst_cnt   <= '0;
            data_buf  <= '0;
            evt_done  <= 1'b0;
            evt_abort <= 1'b0;
        end else begin
            evt_done  <= 1'b0;
            evt_abort <= 1'b0;
            if (sw_reset) begin
                state    <= ST_IDLE;
                armed    <= 1'b0;
                locked   <= 1'b0;
                data_buf <= '0;
                rst_cnt  <= RCW'(RST_CYCLES);
            end else begin
                if (soft_rst_busy) rst_cnt <= rst_cnt - RCW'(1);
                case (state)
                    ST_IDLE: begin
                        if (start_ok) begin
                            state <= ST_READ;
                            armed <= 1'b1;
                        end else if (!enable) begin
                            armed <= 1'b0;
                        end
                    end
                    ST_READ: begin
                        if (m_ack) begin
                            if (m_err) begin
                                evt_abort <= 1'b1;
                                locked    <= 1'b1;
                                armed     <= 1'b0;
                                state     <= ST_IDLE;
                            end else if (!enable) begin
                                armed <= 1'b0;
                                state <= ST_IDLE;
                            end else begin
                                data_buf <= m_rdata & data_mask;
                                state    <= ST_WRITE;
                            end
                        end
                    end
                    ST_WRITE: begin
                        if (m_ack) begin
                            if (m_err) begin
                                evt_abort <= 1'b1;
                                locked    <= 1'b1;
                                armed     <= 1'b0;
                                state     <= ST_IDLE;
                            end else if (last_item && !wrap_any) begin
                                evt_done <= 1'b1;
                                armed    <= 1'b0;
                                state    <= ST_IDLE;
                            end else begin
                                if (last_item) evt_done <= 1'b1;
                                if (enable) begin
                                    state <= ST_READ;
                                end else begin
                                    armed <= 1'b0;
                                    state <= ST_IDLE;
                                end
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R3: a pending request keeps its address and direction until answered.
    a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack && !sw_reset) |=> (m_req && $stable(m_addr) && $stable(m_we)));

    // R11: no bus activity while the engine reset runs.
    a_r11_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_busy |-> !m_req);

    // R10: an abort leaves the engine idle and disarmed.
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        evt_abort |-> (!m_req && !xfer_active));

    // R10: a locked engine never runs.
    a_r10_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !xfer_active);

    // R7: completion and abort never coincide.
    a_r7_done_not_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_done && evt_abort));

endmodule

// File: rtl/dma_xfer_engine.sv
// Module: dma_xfer_engine (top)
// Single-channel DMA engine: sequencer, two address trackers, item counter.
// Assumes configuration inputs are steady while an item is in flight.
module dma_xfer_engine
    import dma_eng_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int CW         = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          start,
    input  logic          sw_reset,
    input  logic [1:0]    src_mode,
    input  logic [1:0]    dst_mode,
    input  logic [1:0]    width,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] xfer_count,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] cur_count,
    output logic          xfer_active,
    output logic          soft_rst_busy,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_size,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    input  logic          m_err,
    input  logic [DW-1:0] m_rdata,
    output logic          evt_done,
    output logic          evt_abort
);

    localparam int NSIDE = 2;

    logic          ctl_clear, ctl_load, ctl_advance;
    logic          ctl_reload_src, ctl_reload_dst, ctl_reload_cnt, ctl_dec;
    logic [2:0]    step;
    logic [1:0]    side_mode   [NSIDE];
    logic [AW-1:0] side_base   [NSIDE];
    logic          side_reload [NSIDE];
    logic [AW-1:0] side_cur    [NSIDE];

    // Per-side inputs gathered for the tracker array.
    always_comb begin
        step           = width_step(width);
        side_mode[0]   = src_mode;
        side_mode[1]   = dst_mode;
        side_base[0]   = src_base;
        side_base[1]   = dst_base;
        side_reload[0] = ctl_reload_src;
        side_reload[1] = ctl_reload_dst;
        cur_src        = side_cur[0];
        cur_dst        = side_cur[1];
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dma_addr_track #(.AW(AW)) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (ctl_clear),
            .load    (ctl_load),
            .reload  (side_reload[s]),
            .advance (ctl_advance),
            .mode    (side_mode[s]),
            .step    (step),
            .base    (side_base[s]),
            .cur     (side_cur[s])
        );
    end

    dma_beat_count #(.CW(CW)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctl_clear),
        .load  (ctl_load || ctl_reload_cnt),
        .dec   (ctl_dec),
        .value (xfer_count),
        .cur   (cur_count)
    );

    dma_seq_fsm #(.AW(AW), .DW(DW), .CW(CW), .RST_CYCLES(RST_CYCLES)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (chan_en),
        .start          (start),
        .sw_reset       (sw_reset),
        .src_mode       (src_mode),
        .dst_mode       (dst_mode),
        .width          (width),
        .cfg_count      (xfer_count),
        .cur_src        (cur_src),
        .cur_dst        (cur_dst),
        .cur_count      (cur_count),
        .m_req          (m_req),
        .m_we           (m_we),
        .m_addr         (m_addr),
        .m_size         (m_size),
        .m_wdata        (m_wdata),
        .m_ack          (m_ack),
        .m_err          (m_err),
        .m_rdata        (m_rdata),
        .ctl_clear      (ctl_clear),
        .ctl_load       (ctl_load),
        .ctl_advance    (ctl_advance),
        .ctl_reload_src (ctl_reload_src),
        .ctl_reload_dst (ctl_reload_dst),
        .ctl_reload_cnt (ctl_reload_cnt),
        .ctl_dec        (ctl_dec),
        .xfer_active    (xfer_active),
        .soft_rst_busy  (soft_rst_busy),
        .evt_done       (evt_done),
        .evt_abort      (evt_abort)
    );

    // R6: an accepted write that is not the last one takes one off the count.
    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we && m_ack && !m_err && !sw_reset && cur_count != CW'(1))
        |=> (cur_count == $past(cur_count) - CW'(1)));

    // R5: a fixed source address does not move on an accepted write.
    a_r5_fixed_src: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we && m_ack && !m_err && !sw_reset && src_mode == AM_FIXED)
        |=> (cur_src == $past(cur_src)));

    // R8: the wrap point reloads the remaining count from the programmed count.
    a_r8_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we && m_ack && !m_err && !sw_reset && cur_count == CW'(1)
         && (src_mode == AM_WRAP || dst_mode == AM_WRAP))
        |=> (cur_count == $past(xfer_count) && evt_done));

endmodule

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;

    localparam int CLK_PERIOD = 10;
    localparam int RSTC       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_req = 1'b0;
    logic        start = 1'b0;
    logic        sw_reset = 1'b0;
    logic [1:0]  src_mode = 2'b00, dst_mode = 2'b00, width = 2'b00;
    logic [31:0] src_base = '0, dst_base = '0;
    logic [15:0] xfer_count = '0;
    logic [31:0] cur_src, cur_dst, m_addr, m_wdata;
    logic [15:0] cur_count;
    logic        xfer_active, soft_rst_busy, m_req, m_we, evt_done, evt_abort;
    logic [1:0]  m_size;
    logic        m_ack = 1'b0, m_err = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        chan_en;

    int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
    int rd_idx = 0, wr_idx = 0, done_cnt = 0, abort_cnt = 0;
    int stop_rd = 0, stop_wr = 0;
    logic idx_clr = 1'b0;
    logic [1:0]  g_w = 0, g_sm = 0, g_dm = 0;
    logic [31:0] g_sb = 0, g_db = 0;
    int g_n = 1;

    assign chan_en = en_req && !((stop_wr != 0 && wr_idx >= stop_wr) ||
                                 (stop_rd != 0 && rd_idx >= stop_rd));

    dma_xfer_engine #(.AW(32), .DW(32), .CW(16), .RST_CYCLES(RSTC)) i_dma_xfer_engine (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start(start), .sw_reset(sw_reset),
        .src_mode(src_mode), .dst_mode(dst_mode), .width(width),
        .src_base(src_base), .dst_base(dst_base), .xfer_count(xfer_count),
        .cur_src(cur_src), .cur_dst(cur_dst), .cur_count(cur_count),
        .xfer_active(xfer_active), .soft_rst_busy(soft_rst_busy),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
        .evt_done(evt_done), .evt_abort(evt_abort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rd_val(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] mask_of(input logic [1:0] w);
        return (w == 2'b01) ? 32'h0000_00FF : (w == 2'b10) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int step_of(input logic [1:0] w);
        return (w == 2'b01) ? 1 : (w == 2'b10) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [1:0] md,
                                             input logic [1:0] w, input int k, input int n);
        if (md == 2'b10) return b;
        if (md == 2'b11) return b + 32'((k % n) * step_of(w));
        return b + 32'(k * step_of(w));
    endfunction

    // Bus model: answer every other cycle, check each accepted access.
    always @(negedge clk) begin
        if (idx_clr) begin
            rd_idx = 0; wr_idx = 0;
        end
        if (m_ack) begin
            m_ack = 1'b0; m_err = 1'b0;
        end else if (m_req) begin
            m_ack   = 1'b1;
            m_err   = (m_addr[31:28] == 4'hF);
            m_rdata = m_we ? 32'h0 : rd_val(m_addr);
            if (!m_err) begin
                if (!m_we) begin
                    m_chk++;
                    if (m_addr !== exp_addr(g_sb, g_sm, g_w, rd_idx, g_n)) begin
                        m_fail++;
                        $display("FAIL R3 read addr: got %h exp %h", m_addr, exp_addr(g_sb, g_sm, g_w, rd_idx, g_n));
                    end
                    rd_idx++;
                end else begin
                    m_chk += 3;
                    if (m_addr !== exp_addr(g_db, g_dm, g_w, wr_idx, g_n)) begin
                        m_fail++;
                        $display("FAIL R5 write addr: got %h exp %h", m_addr, exp_addr(g_db, g_dm, g_w, wr_idx, g_n));
                    end
                    if (m_wdata !== (rd_val(exp_addr(g_sb, g_sm, g_w, wr_idx, g_n)) & mask_of(g_w))) begin
                        m_fail++;
                        $display("FAIL R4 write data: got %h exp %h", m_wdata,
                                 rd_val(exp_addr(g_sb, g_sm, g_w, wr_idx, g_n)) & mask_of(g_w));
                    end
                    if (m_size !== ((g_w == 2'b01) ? 2'd0 : (g_w == 2'b10) ? 2'd1 : 2'd2)) begin
                        m_fail++;
                        $display("FAIL R4 size: got %0d exp %0d", m_size,
                                 (g_w == 2'b01) ? 0 : (g_w == 2'b10) ? 1 : 2);
                    end
                    wr_idx++;
                end
            end
        end
    end

    // Event pulse counters.
    always @(negedge clk) begin
        if (idx_clr) begin
            done_cnt = 0; abort_cnt = 0;
        end else begin
            if (evt_done)  done_cnt++;
            if (evt_abort) abort_cnt++;
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h exp %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk + m_chk, n_fail + m_fail);
        $finish;
    endtask

    task automatic setup(input logic [1:0] w, input logic [1:0] sm, input logic [1:0] dm,
                         input int n, input logic [31:0] sb, input logic [31:0] db);
        g_w = w; g_sm = sm; g_dm = dm; g_n = n; g_sb = sb; g_db = db;
        width = w; src_mode = sm; dst_mode = dm; xfer_count = 16'(n);
        src_base = sb; dst_base = db;
        idx_clr = 1'b1;
        @(negedge clk); @(negedge clk);
        idx_clr = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 400 && xfer_active; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_case(input logic [1:0] w, input logic [1:0] sm, input logic [1:0] dm, input int n);
        logic [31:0] sb, db;
        sb = 32'h1000_0100 + 32'(n * 16);
        db = 32'h2000_0800 + 32'(w * 64);
        stop_rd = 0; stop_wr = 0; en_req = 1'b1;
        setup(w, sm, dm, n, sb, db);
        pulse_start();
        chk(xfer_active == 1'b1, "R2 armed after start", xfer_active, 1);
        chk(cur_count == 16'(n), "R2 count loaded", cur_count, n);
        chk(m_req && !m_we && m_addr == sb, "R3 first read", m_addr, sb);
        wait_idle();
        chk(wr_idx == n, "R6 item writes", wr_idx, n);
        chk(cur_count == 0, "R6 remaining zero", cur_count, 0);
        chk(cur_src == exp_addr(sb, sm, w, n, n + 1), "R5 final src", cur_src, exp_addr(sb, sm, w, n, n + 1));
        chk(cur_dst == exp_addr(db, dm, w, n, n + 1), "R5 final dst", cur_dst, exp_addr(db, dm, w, n, n + 1));
        chk(done_cnt == 1, "R7 one done pulse", done_cnt, 1);
        chk(!m_req && !xfer_active, "R7 stopped", m_req, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
    end

    initial begin
        int busy_cycles, reqs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!m_req && !xfer_active && !soft_rst_busy, "R1 idle after reset", m_req, 0);
        chk(cur_count == 0 && cur_src == 0 && cur_dst == 0, "R1 regs cleared", cur_count, 0);

        // R2 start ignored while disabled, and with a zero count
        en_req = 1'b0;
        setup(2'b00, 2'b00, 2'b00, 3, 32'h1000_0000, 32'h2000_0000);
        pulse_start();
        repeat (4) @(negedge clk);
        chk(!xfer_active && !m_req && cur_count == 0, "R2 disabled start ignored", xfer_active, 0);
        en_req = 1'b1;
        setup(2'b00, 2'b00, 2'b00, 0, 32'h1000_0000, 32'h2000_0000);
        pulse_start();
        repeat (4) @(negedge clk);
        chk(!xfer_active && !m_req, "R2 zero count ignored", xfer_active, 0);

        // R3 R4 R5 R6 R7 sweep over widths, modes (incl. reserved) and counts
        for (int w = 0; w < 4; w++)
            for (int sm = 0; sm < 3; sm++)
                for (int dm = 0; dm < 3; dm++)
                    for (int n = 1; n <= 3; n += 2)
                        run_case(2'(w), 2'(sm), 2'(dm), n);

        // R8 wrap on source, increment destination, stop after six items
        stop_rd = 0; stop_wr = 6; en_req = 1'b1;
        setup(2'b00, 2'b11, 2'b00, 2, 32'h1000_4000, 32'h2000_4000);
        pulse_start();
        wait_idle();
        chk(wr_idx == 6, "R8 items over three periods", wr_idx, 6);
        chk(done_cnt == 3, "R8 done per reload", done_cnt, 3);
        chk(cur_count == 2, "R8 count reloaded", cur_count, 2);
        chk(cur_src == 32'h1000_4000, "R8 src reloaded", cur_src, 32'h1000_4000);
        chk(cur_dst == 32'h2000_4018, "R8 dst keeps stepping", cur_dst, 32'h2000_4018);
        chk(!m_req && !xfer_active, "R9 idle after disable", xfer_active, 0);

        // R9 disable during the second read: read data dropped
        stop_wr = 0; stop_rd = 2; en_req = 1'b1;
        setup(2'b00, 2'b00, 2'b00, 4, 32'h1000_8000, 32'h2000_8000);
        pulse_start();
        wait_idle();
        chk(wr_idx == 1, "R9 buffered read not written", wr_idx, 1);
        chk(cur_count == 3, "R9 count after disable", cur_count, 3);
        chk(!xfer_active && done_cnt == 0, "R9 disarmed no done", xfer_active, 0);
        stop_rd = 0;

        // R10 bus error on the first read
        setup(2'b00, 2'b00, 2'b00, 3, 32'hF000_0000, 32'h2000_0000);
        pulse_start();
        wait_idle();
        chk(abort_cnt == 1, "R10 abort pulse", abort_cnt, 1);
        chk(wr_idx == 0 && cur_count == 3, "R10 nothing written", wr_idx, 0);
        chk(!xfer_active && !m_req, "R10 idle", xfer_active, 0);
        setup(2'b00, 2'b00, 2'b00, 3, 32'h1000_0000, 32'h2000_0000);
        pulse_start();
        reqs = 0;
        repeat (10) begin
            if (m_req || xfer_active) reqs++;
            @(negedge clk);
        end
        chk(reqs == 0, "R10 locked start ignored", reqs, 0);

        // R11 engine reset timing and unlock
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
        busy_cycles = 0; reqs = 0;
        repeat (10) begin
            if (soft_rst_busy) busy_cycles++;
            if (m_req) reqs++;
            @(negedge clk);
        end
        chk(busy_cycles == RSTC, "R11 busy length", busy_cycles, RSTC);
        chk(reqs == 0, "R11 no requests", reqs, 0);
        chk(cur_count == 0 && cur_src == 0 && cur_dst == 0, "R11 regs cleared", cur_count, 0);
        run_case(2'b10, 2'b00, 2'b10, 3);

        summary();
    end

endmodule